// File: doc/BRIEF.md
# Byte-Packing Transmit Queue with Drain-to-Empty Interrupt

This block is the transmit-side staging store of a serial peripheral. A processor loads it over a small register bus. It can load one, two or four bytes with a single write, and the width depends only on which of three data addresses it targets. The block holds up to sixteen bytes. A readable level register reports how many bytes are waiting, and a downstream line encoder takes them out one at a time through a valid/ready handshake.

The only transmit interrupt source is the moment the queue runs dry. The event sets a sticky flag when the byte count goes from exactly one to zero in a cycle, and at no other time. The interrupt line is that flag gated by an enable bit, and software clears the flag by writing a one to it. A load that does not fit in the free space is discarded whole and leaves a sticky overflow flag behind.

Top module: `txq_top`

## Requirements
- R1: After synchronous reset the queue is empty: level reads 0, `tx_valid` is 0, both status flags are 0, the enable bit is 0 and `irq` is 0.
- R2: A write to address 0 appends `bus_wdata[7:0]` and raises the level by 1.
- R3: A write to address 1 appends two bytes, `bus_wdata[7:0]` first and then `bus_wdata[15:8]`, and raises the level by 2.
- R4: A write to address 2 appends four bytes in the order `[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`, and raises the level by 4.
- R5: A read of address 3 returns the current level (0 to 16) in bits [4:0] on `bus_rdata` one cycle after the read strobe.
- R6: A load whose byte count exceeds 16 minus the level is discarded completely, the level is unchanged, and sticky status bit 1 (overflow) is set.
- R7: `tx_valid` is high exactly when the level is nonzero, and `tx_data` shows the oldest byte. A byte is removed in a cycle where both `tx_valid` and `tx_ready` are high.
- R8: Status bit 0 (drain flag, read at address 4) is set when the level goes from 1 to 0 in one cycle, and no other level change sets it.
- R9: When a load and a removal happen in the same cycle, the level changes by the loaded count minus one. If the result is nonzero, the drain flag is not set.
- R10: `irq` equals the drain flag ANDed with the enable bit, which is bit 0 at address 5 (read/write).
- R11: Writing to address 4 clears status bit 0 when `bus_wdata[0]` is 1 and clears bit 1 when `bus_wdata[1]` is 1. A set event in the same cycle wins.
- R12: The queue holds 16 bytes. A load that brings the level to exactly 16 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Oldest queued byte |
| tx_valid | output | 1 | Queue not empty |
| tx_ready | input | 1 | Downstream takes the byte |
| irq | output | 1 | Drain interrupt |

## Verification
The bench loads the queue with a mix of one-, two- and four-byte writes whose byte values all differ. The order of bytes coming out therefore tells a lane-order mistake apart from a pointer-wrap mistake. A load that would overrun the free space sits between loads that fit, and a single byte then fills the last slot exactly. These separate the all-or-nothing drop from a partial enqueue and from an off-by-one capacity limit. Loads made in the same cycle as a removal, first at level one and then with a wider load, separate the true one-to-zero detector from one that fires on any removal or on a transient empty state.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    A_PUSH1  = 3'd0,
    A_PUSH2  = 3'd1,
    A_PUSH4  = 3'd2,
    A_LEVEL  = 3'd3,
    A_STATUS = 3'd4,
    A_ENABLE = 3'd5
  } reg_addr_e;

  localparam int LANES = 4;
endpackage

// File: rtl/txq_pack.sv
module txq_pack #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [LW-1:0] level,
  output logic [2:0]    push_cnt,
  output logic          push_en,
  output logic          drop
);
  import txq_pkg::*;
  logic [2:0]    req_cnt;
  logic [LW-1:0] free_slots;

  always_comb begin
    req_cnt = 3'd0;
    if (wr) begin
      case (addr)
        A_PUSH1: req_cnt = 3'd1;
        A_PUSH2: req_cnt = 3'd2;
        A_PUSH4: req_cnt = 3'd4;
        default: req_cnt = 3'd0;
      endcase
    end
  end

  assign free_slots = LW'(DEPTH) - level;
  assign push_en    = (req_cnt != 3'd0) && (LW'(req_cnt) <= free_slots);
  assign drop       = (req_cnt != 3'd0) && (LW'(req_cnt) >  free_slots);
  assign push_cnt   = push_en ? req_cnt : 3'd0;
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [2:0]    push_cnt,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [LW-1:0] level,
  output logic          drain_evt
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q, level_d;

  always_ff @(posedge clk) begin
    for (int i = 0; i < txq_pkg::LANES; i++) begin
      if (push_en && (3'(i) < push_cnt))
        mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
    end
  end

  assign level_d = level_q + LW'(push_cnt) - LW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      wr_ptr  <= wr_ptr + PW'(push_cnt);
      rd_ptr  <= rd_ptr + PW'(pop);
      level_q <= level_d;
    end
  end

  assign head      = mem[rd_ptr];
  assign level     = level_q;
  assign drain_evt = (level_q == LW'(1)) && (level_d == '0);
endmodule

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    addr,
  input  logic [1:0]    wbits,
  input  logic [LW-1:0] level,
  input  logic          drain_evt,
  input  logic          ovf_evt,
  output logic [31:0]   rdata,
  output logic          drain_flag,
  output logic          irq
);
  import txq_pkg::*;
  logic drain_q, ovf_q, en_q, irq_q;
  logic drain_d, ovf_d, en_d, st_wr;

  assign st_wr   = bus_wr && (addr == A_STATUS);
  assign drain_d = drain_evt | (drain_q & ~(st_wr & wbits[0]));
  assign ovf_d   = ovf_evt   | (ovf_q   & ~(st_wr & wbits[1]));
  assign en_d    = (bus_wr && addr == A_ENABLE) ? wbits[0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      rdata   <= '0;
    end else begin
      drain_q <= drain_d;
      ovf_q   <= ovf_d;
      en_q    <= en_d;
      irq_q   <= drain_d & en_d;
      if (bus_rd) begin
        case (addr)
          A_LEVEL:  rdata <= {{(32-LW){1'b0}}, level};
          A_STATUS: rdata <= {30'd0, ovf_q, drain_q};
          A_ENABLE: rdata <= {31'd0, en_q};
          default:  rdata <= '0;
        endcase
      end
    end
  end

  assign drain_flag = drain_q;
  assign irq        = irq_q;
endmodule

// File: rtl/txq_top.sv
module txq_top #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        irq
);
  logic [LW-1:0] level;
  logic [2:0]    push_cnt;
  logic          push_en, drop, pop, drain_evt, drain_flag;

  assign tx_valid = (level != '0);
  assign pop      = tx_valid & tx_ready;

  txq_pack #(.DEPTH(DEPTH), .LW(LW)) pack_i (
    .wr(bus_wr), .addr(bus_addr), .level(level),
    .push_cnt(push_cnt), .push_en(push_en), .drop(drop)
  );

  txq_store #(.DEPTH(DEPTH), .LW(LW)) store_i (
    .clk(clk), .rst(rst), .push_en(push_en), .push_cnt(push_cnt),
    .push_data(bus_wdata), .pop(pop), .head(tx_data), .level(level),
    .drain_evt(drain_evt)
  );

  txq_regs #(.LW(LW)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .addr(bus_addr), .wbits(bus_wdata[1:0]), .level(level),
    .drain_evt(drain_evt), .ovf_evt(drop), .rdata(bus_rdata),
    .drain_flag(drain_flag), .irq(irq)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [LW-1:0] level,
  input logic          drain_flag
);
  // R8
  drain_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_flag) |-> ($past(level) == LW'(1)) && (level == '0));

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd2 && level > LW'(DEPTH - 4) && !(tx_valid && tx_ready))
      |=> level == $past(level));

  // R7
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> $stable(tx_data) && tx_valid);

  // R9
  busy_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && level > LW'(1)) |=> !$rose(drain_flag));
endmodule

bind txq_top txq_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .level(level), .drain_flag(drain_flag)
);

// File: tb/txq_top_tb.sv
module txq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst, bus_wr, bus_rd, tx_ready;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mq[$];

  always #5 clk = ~clk;

  txq_top dut_i (.*);

  // {addr, wdata, expected level}
  localparam logic [39:0] VEC [7] = '{
    {3'd0, 32'h000000A1, 5'd1},
    {3'd1, 32'h0000B2B1, 5'd3},
    {3'd2, 32'hC4C3C2C1, 5'd7},
    {3'd2, 32'hD4D3D2D1, 5'd11},
    {3'd2, 32'hE4E3E2E1, 5'd15},
    {3'd1, 32'h0000F2F1, 5'd15},
    {3'd0, 32'h00000055, 5'd16}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input logic [2:0] a);
    return (a == 3'd0) ? 1 : (a == 3'd1) ? 2 : (a == 3'd2) ? 4 : 0;
  endfunction

  task automatic model_push(input logic [2:0] a, input logic [31:0] d);
    int n = cnt_of(a);
    if (n != 0 && n <= 16 - mq.size())
      for (int i = 0; i < n; i++) mq.push_back(d[8*i +: 8]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
    model_push(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pop_one(input string req);
    @(negedge clk);
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, {24'd0, tx_data}, {24'd0, mq[0]});
    tx_ready = 1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 0;
    void'(mq.pop_front());
  endtask

  task automatic push_pop(input logic [2:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    chk(req, {24'd0, tx_data}, {24'd0, mq[0]});
    bus_wr = 1; bus_addr = a; bus_wdata = d; tx_ready = 1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; tx_ready = 0;
    void'(mq.pop_front());
    model_push(a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst = 1; bus_wr = 0; bus_rd = 0; tx_ready = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 valid", {31'd0, tx_valid}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(3'd3, r); chk("R1 level", r, 0);
    rd(3'd4, r); chk("R1 status", r, 0);

    // R2 R3 R4 R6 R12 table of loads with level readback (R5)
    foreach (VEC[i]) begin
      wr(VEC[i][39:37], VEC[i][36:5]);
      rd(3'd3, r);
      chk("R5 level", r, {27'd0, VEC[i][4:0]});
      chk("R5 model", r, mq.size());
    end
    rd(3'd4, r); chk("R6 overflow", r, 32'd2);
    // drain all, checking little-endian order (R3 R4 R7)
    for (int k = 0; k < 16; k++) pop_one("R4 order");
    chk("R7 empty", {31'd0, tx_valid}, 0);
    rd(3'd4, r); chk("R8 drain", r, 32'd3);
    chk("R10 disabled", {31'd0, irq}, 0);

    wr(3'd5, 32'd1);
    chk("R10 enabled", {31'd0, irq}, 1);
    wr(3'd4, 32'd1);
    chk("R11 irq clear", {31'd0, irq}, 0);
    rd(3'd4, r); chk("R11 drain cleared", r, 32'd2);
    wr(3'd4, 32'd2);
    rd(3'd4, r); chk("R11 ovf cleared", r, 0);

    // R9 load and removal in one cycle
    wr(3'd0, 32'h11);
    push_pop(3'd0, 32'h22, "R9 head");
    rd(3'd3, r); chk("R9 level", r, 1);
    rd(3'd4, r); chk("R9 no drain", r, 0);
    push_pop(3'd1, 32'h4433, "R9 head2");
    rd(3'd3, r); chk("R9 level2", r, 2);
    pop_one("R9 pop");
    rd(3'd4, r); chk("R8 not yet", r, 0);
    pop_one("R8 pop");
    rd(3'd4, r); chk("R8 set", r, 1);
    chk("R10 irq", {31'd0, irq}, 1);
    wr(3'd4, 32'd1);

    // R12 exact fill, then R6 drop at full
    for (int k = 0; k < 4; k++) wr(3'd2, 32'h01020304 + k);
    rd(3'd3, r); chk("R12 full", r, 16);
    wr(3'd0, 32'h99);
    rd(3'd3, r); chk("R6 full drop", r, 16);
    rd(3'd4, r); chk("R6 ovf", r, 2);
    pop_one("R12 head");

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    mq.delete();
    chk("R1 valid after", {31'd0, tx_valid}, 0);
    chk("R1 irq after", {31'd0, irq}, 0);
    rd(3'd3, r); chk("R1 level after", r, 0);
    rd(3'd5, r); chk("R1 enable after", r, 0);
    finish_run();
  end
endmodule